// File: doc/BRIEF.md
# Sorted Acceptance-Filter Table Inserter

This block maintains an identifier table for a receive acceptance filter in a single-port RAM of `DEPTH` 32-bit words, and keeps it sorted as entries are added one at a time. The table has two sections. The low section holds 16-bit standard-format entries packed two to a word. Directly above it sits the extended-format section, which holds one 32-bit entry per word. A requester offers an identifier, a format flag and a 3-bit controller index through a valid/ready handshake. The block then finds the sorted position, shifts the later entries up by one slot, and rewrites the affected words.

A standard entry can need a new word. This happens when the standard count is even. In that case the whole extended section first moves up by one word. After each insert the block presents the byte offset where the extended section starts and the byte offset of the table end. Downstream logic takes the start of the standard section as offset 0. It uses the extended start as the boundary of the standard group and the table end as the boundary of the extended group.

While the table is being changed, the block holds the filter in its off mode through `filterOff`. A request that would overflow the RAM is accepted, answered with a one-cycle error pulse and discarded.

Top module: `acc_table_inserter`

## Requirements
- R1: The standard entry is `{reqCtrl[2:0], 2'b00, reqId[10:0]}`. The controller index sits in bits 15:13 and bits 12:11 are zero.
- R2: The extended entry is `{reqCtrl[2:0], reqId[28:0]}`.
- R3: Standard entries stay in ascending unsigned order over the whole standard section. Each word holds the earlier entry in bits 31:16 and the next entry in bits 15:0. A new entry equal to an existing one goes after it.
- R4: When the standard count is odd, bits 15:0 of the last standard word hold 16'hFFFF.
- R5: A standard insert made while the standard count is even and extended entries exist moves every extended word up by one address, and their order is kept.
- R6: Extended entries stay in ascending unsigned 32-bit order, one per word, starting at word ceil(S/2). A new entry goes before the first existing entry that is strictly greater than it.
- R7: When `done` is high and while idle, `extStartPtr` equals ceil(S/2)*4 and `tableEndPtr` equals `extStartPtr` + E*4, both in bytes. S and E are the standard and extended counts.
- R8: A request is refused when ceil(S/2)+E >= DEPTH. In that case `fullErr` pulses for one cycle, in the cycle after acceptance. There is no `done` pulse, no RAM write, and the counts and pointers do not change.
- R9: `filterOff` is high from the cycle after a non-refused request is accepted until the `done` cycle, where it is low. Every RAM write takes place while `filterOff` is high.
- R10: `reqReady` is high only when idle, and `busy` is high whenever the block is not idle. `reqValid` offered while busy is ignored. `done` is a single-cycle pulse after which `reqReady` returns.
- R11: After reset both counts are zero, both pointers are zero, `reqReady` is 1, and `busy`, `done`, `fullErr` and `filterOff` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Insert request valid |
| reqReady | output | 1 | Block can accept a request |
| reqExt | input | 1 | 1 = extended entry, 0 = standard entry |
| reqCtrl | input | 3 | Controller index |
| reqId | input | 29 | Identifier (standard uses bits 10:0) |
| busy | output | 1 | Insert or refusal in progress |
| done | output | 1 | One-cycle pulse when an insert completes |
| fullErr | output | 1 | One-cycle pulse when a request is refused |
| filterOff | output | 1 | Filter held off while the table changes |
| extStartPtr | output | AW+3 | Byte offset of the extended section |
| tableEndPtr | output | AW+3 | Byte offset of the table end |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | AW | RAM word address |
| ramWdata | output | 32 | RAM write data |
| ramRdata | input | 32 | RAM read data, valid the cycle after a read |

## Verification
In one word write, two functions can meet: placing the new standard entry and filling the empty half with 16'hFFFF. The other case where functions meet is a standard insert that relocates the extended section before sorting. The bench provokes both with a reference model. It adds standard entries at even counts, with extended entries present, and with identifiers chosen to land first, last and on duplicates. After every operation it compares each occupied RAM word and both pointers against the model. It also probes the handshake by raising `reqValid` with junk while busy. A later table comparison then shows whether that junk entry was wrongly taken.

// File: rtl/ati_pkg.sv
package ati_pkg;
  localparam int CTRL_W   = 3;
  localparam int STD_ID_W = 11;
  localparam int EXT_ID_W = 29;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture a new request, clear scan state
    logic mergeEn;   // current cycle merges one table word
    logic oldAbsent; // word under merge holds no old entry
    logic extMode;   // operation targets extended section
    logic moveSel;   // write data is the word just read (section move)
  } dpCtl_t;
endpackage

// File: rtl/ati_datapath.sv
module ati_datapath
  import ati_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [CTRL_W-1:0]   reqCtrl,
  input  logic [EXT_ID_W-1:0] reqId,
  input  logic [WORD_W-1:0]   ramRdata,
  output logic [WORD_W-1:0]   ramWdata,
  output logic                mergeDirty
);
  logic [HALF_W-1:0] stdEntry;
  logic [WORD_W-1:0] extEntry;
  logic [WORD_W-1:0] carry;
  logic              inserted;

  logic [WORD_W-1:0] oldWord;
  logic [HALF_W-1:0] outHi, outLo, cHi, cLo;
  logic              insHi, insLo;
  logic [WORD_W-1:0] extOut, extCarry, mergedWord, carryNext;
  logic              extIns, insNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdEntry <= '0;
      extEntry <= '0;
      carry    <= '1;
      inserted <= 1'b0;
    end else if (ctl.loadReq) begin
      stdEntry <= {reqCtrl, 2'b00, reqId[STD_ID_W-1:0]};
      extEntry <= {reqCtrl, reqId};
      carry    <= '1;
      inserted <= 1'b0;
    end else if (ctl.mergeEn) begin
      carry    <= carryNext;
      inserted <= insNext;
    end
  end

  // standard: two half-word slots per word, upper slot first
  always_comb begin
    oldWord = ctl.oldAbsent ? '1 : ramRdata;
    if (!inserted) begin
      if (oldWord[31:16] > stdEntry) begin
        outHi = stdEntry; insHi = 1'b1; cHi = oldWord[31:16];
      end else begin
        outHi = oldWord[31:16]; insHi = 1'b0; cHi = carry[HALF_W-1:0];
      end
    end else begin
      outHi = carry[HALF_W-1:0]; insHi = 1'b1; cHi = oldWord[31:16];
    end
    if (!insHi) begin
      if (oldWord[15:0] > stdEntry) begin
        outLo = stdEntry; insLo = 1'b1; cLo = oldWord[15:0];
      end else begin
        outLo = oldWord[15:0]; insLo = 1'b0; cLo = cHi;
      end
    end else begin
      outLo = cHi; insLo = 1'b1; cLo = oldWord[15:0];
    end
  end

  // extended: one entry per word
  always_comb begin
    if (!inserted) begin
      if (ctl.oldAbsent || (ramRdata > extEntry)) begin
        extOut = extEntry; extIns = 1'b1; extCarry = ramRdata;
      end else begin
        extOut = ramRdata; extIns = 1'b0; extCarry = carry;
      end
    end else begin
      extOut = carry; extIns = 1'b1; extCarry = ramRdata;
    end
  end

  always_comb begin
    mergedWord = ctl.extMode ? extOut : {outHi, outLo};
    insNext    = ctl.extMode ? extIns : insLo;
    carryNext  = ctl.extMode ? extCarry : {16'hFFFF, cLo};
    mergeDirty = ctl.mergeEn & insNext;
    ramWdata   = ctl.moveSel ? ramRdata : mergedWord;
  end

  // R3
  std_pair_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mergeEn && !ctl.extMode && mergeDirty) |-> (ramWdata[31:16] <= ramWdata[15:0]));

  // R6
  ext_after_smaller_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mergeEn && ctl.extMode && !inserted && !ctl.oldAbsent && mergeDirty)
      |-> (ramRdata > extEntry));
endmodule

// File: rtl/ati_ctrl.sv
module ati_ctrl
  import ati_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqExt,
  output logic                reqReady,
  output logic                busy,
  output logic                done,
  output logic                fullErr,
  output logic                filterOff,
  output logic [$clog2(DEPTH)+2:0] extStartPtr,
  output logic [$clog2(DEPTH)+2:0] tableEndPtr,
  output logic                ramEn,
  output logic                ramWe,
  output logic [$clog2(DEPTH)-1:0] ramAddr,
  output dpCtl_t              ctl,
  input  logic                mergeDirty
);
  localparam int AW    = $clog2(DEPTH);
  localparam int WI_W  = AW + 2;
  localparam int SC_W  = AW + 2;
  localparam int EC_W  = AW + 1;
  localparam int PTR_W = AW + 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MVRD, ST_MVWR, ST_SCRD, ST_SCMG, ST_DONE, ST_FULL
  } state_t;

  state_t          state, stateNext;
  logic [SC_W-1:0] stdCnt, stdCntNext;
  logic [EC_W-1:0] extCnt, extCntNext;
  logic [WI_W-1:0] wIdx, wIdxNext;
  logic            extMode, extModeNext;

  logic [SC_W-1:0] stdCntP1;
  logic [WI_W-1:0] stdWords, tableWords, oldEnd, lastNew, entrySum;
  logic            fullNow;

  always_comb begin
    stdCntP1   = stdCnt + SC_W'(1);
    stdWords   = WI_W'(stdCntP1 >> 1);
    tableWords = stdWords + WI_W'(extCnt);
    fullNow    = tableWords >= WI_W'(DEPTH);
    oldEnd     = extMode ? tableWords : stdWords;
    lastNew    = extMode ? tableWords : WI_W'(stdCnt >> 1);
    entrySum   = WI_W'(stdCnt) + WI_W'(extCnt);
    extStartPtr = PTR_W'(stdWords) << 2;
    tableEndPtr = PTR_W'(tableWords) << 2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stdCnt  <= '0;
      extCnt  <= '0;
      wIdx    <= '0;
      extMode <= 1'b0;
    end else begin
      state   <= stateNext;
      stdCnt  <= stdCntNext;
      extCnt  <= extCntNext;
      wIdx    <= wIdxNext;
      extMode <= extModeNext;
    end
  end

  always_comb begin
    stateNext   = state;
    stdCntNext  = stdCnt;
    extCntNext  = extCnt;
    wIdxNext    = wIdx;
    extModeNext = extMode;
    ctl         = '0;
    ctl.extMode = extMode;
    ramEn       = 1'b0;
    ramWe       = 1'b0;
    ramAddr     = AW'(wIdx);
    reqReady    = 1'b0;
    done        = 1'b0;
    fullErr     = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (fullNow) begin
            stateNext = ST_FULL;
          end else begin
            ctl.loadReq = 1'b1;
            extModeNext = reqExt;
            if (!reqExt && !stdCnt[0] && (extCnt != '0)) begin
              wIdxNext  = tableWords - WI_W'(1);
              stateNext = ST_MVRD;
            end else begin
              wIdxNext  = reqExt ? stdWords : '0;
              stateNext = ST_SCRD;
            end
          end
        end
      end
      ST_MVRD: begin
        ramEn     = 1'b1;
        stateNext = ST_MVWR;
      end
      ST_MVWR: begin
        ramEn       = 1'b1;
        ramWe       = 1'b1;
        ramAddr     = AW'(wIdx + WI_W'(1));
        ctl.moveSel = 1'b1;
        if (wIdx == stdWords) begin
          wIdxNext  = '0;
          stateNext = ST_SCRD;
        end else begin
          wIdxNext  = wIdx - WI_W'(1);
          stateNext = ST_MVRD;
        end
      end
      ST_SCRD: begin
        ramEn     = wIdx < oldEnd;
        stateNext = ST_SCMG;
      end
      ST_SCMG: begin
        ctl.mergeEn   = 1'b1;
        ctl.oldAbsent = wIdx >= oldEnd;
        ramEn         = mergeDirty;
        ramWe         = mergeDirty;
        if (wIdx == lastNew) begin
          if (extMode) extCntNext = extCnt + EC_W'(1);
          else         stdCntNext = stdCnt + SC_W'(1);
          stateNext = ST_DONE;
        end else begin
          wIdxNext  = wIdx + WI_W'(1);
          stateNext = ST_SCRD;
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_FULL: begin
        fullErr   = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy      = state != ST_IDLE;
  assign filterOff = (state == ST_MVRD) || (state == ST_MVWR) ||
                     (state == ST_SCRD) || (state == ST_SCMG);

  // R10
  one_entry_per_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (entrySum == $past(entrySum) + WI_W'(1)));

  // R8
  refuse_only_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullErr |-> ($past(tableWords) >= WI_W'(DEPTH)) && $stable(entrySum));

  // R9
  write_while_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && ramWe) |-> filterOff);

  // R5
  move_up_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ctl.moveSel) |-> (ramAddr == $past(ramAddr) + AW'(1)) && !$past(ramWe));
endmodule

// File: rtl/acc_table_inserter.sv
module acc_table_inserter
  import ati_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqExt,
  input  logic [2:0]               reqCtrl,
  input  logic [28:0]              reqId,
  output logic                     busy,
  output logic                     done,
  output logic                     fullErr,
  output logic                     filterOff,
  output logic [$clog2(DEPTH)+2:0] extStartPtr,
  output logic [$clog2(DEPTH)+2:0] tableEndPtr,
  output logic                     ramEn,
  output logic                     ramWe,
  output logic [$clog2(DEPTH)-1:0] ramAddr,
  output logic [31:0]              ramWdata,
  input  logic [31:0]              ramRdata
);
  dpCtl_t ctl;
  logic   mergeDirty;

  ati_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqExt(reqExt),
    .reqReady(reqReady), .busy(busy), .done(done), .fullErr(fullErr),
    .filterOff(filterOff), .extStartPtr(extStartPtr), .tableEndPtr(tableEndPtr),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ctl(ctl),
    .mergeDirty(mergeDirty)
  );

  ati_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCtrl(reqCtrl), .reqId(reqId),
    .ramRdata(ramRdata), .ramWdata(ramWdata), .mergeDirty(mergeDirty)
  );
endmodule

// File: tb/acc_table_inserter_tb.sv
module acc_table_inserter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqExt = 0;
  logic [2:0] reqCtrl = 0;
  logic [28:0] reqId = 0;
  logic reqReady, busy, done, fullErr, filterOff;
  logic [AW+2:0] extStartPtr, tableEndPtr;
  logic ramEn, ramWe;
  logic [AW-1:0] ramAddr;
  logic [31:0] ramWdata, ramRdata;
  logic [31:0] mem [DEPTH];

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] stdM [2*DEPTH+2];
  logic [31:0] extM [DEPTH+1];
  int sCnt = 0, eCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_table_inserter #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqExt(reqExt), .reqCtrl(reqCtrl), .reqId(reqId), .busy(busy),
    .done(done), .fullErr(fullErr), .filterOff(filterOff),
    .extStartPtr(extStartPtr), .tableEndPtr(tableEndPtr),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    if (ramEn) begin
      if (ramWe) mem[ramAddr] <= ramWdata;
      else       ramRdata <= mem[ramAddr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: every write happens with the filter off; idle means filter on
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (ramEn && ramWe) chk(filterOff == 1'b1, "R9 write with filter on", {31'd0, filterOff}, 32'd1);
      if (!busy && filterOff) chk(1'b0, "R9 filterOff while idle", 32'd1, 32'd0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] expStdWord(int w);
    logic [15:0] lo;
    lo = (2*w+1 < sCnt) ? stdM[2*w+1] : 16'hFFFF;
    return {stdM[2*w], lo};
  endfunction

  task automatic modelAdd(input bit ext, input logic [15:0] s16, input logic [31:0] e32);
    int pos;
    if (!ext) begin
      pos = sCnt;
      for (int i = sCnt - 1; i >= 0; i--) if (stdM[i] > s16) pos = i;
      for (int i = sCnt; i > pos; i--) stdM[i] = stdM[i-1];
      stdM[pos] = s16;
      sCnt++;
    end else begin
      pos = eCnt;
      for (int i = eCnt - 1; i >= 0; i--) if (extM[i] > e32) pos = i;
      for (int i = eCnt; i > pos; i--) extM[i] = extM[i-1];
      extM[pos] = e32;
      eCnt++;
    end
  endtask

  task automatic checkTable(input string extTag);
    int sw;
    sw = (sCnt + 1) / 2;
    for (int w = 0; w < sw; w++) begin
      if (2*w+1 >= sCnt) chk(mem[w] == expStdWord(w), "R4 padded last std word", mem[w], expStdWord(w));
      else               chk(mem[w] == expStdWord(w), "R3 std word", mem[w], expStdWord(w));
    end
    for (int i = 0; i < eCnt; i++)
      chk(mem[sw+i] == extM[i], extTag, mem[sw+i], extM[i]);
    chk(extStartPtr == (AW+3)'(sw*4), "R7 extStartPtr", 32'(extStartPtr), 32'(sw*4));
    chk(tableEndPtr == (AW+3)'((sw+eCnt)*4), "R7 tableEndPtr", 32'(tableEndPtr), 32'((sw+eCnt)*4));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    sCnt = 0; eCnt = 0;
    @(negedge clk);
    chk(reqReady && !busy && !done && !fullErr && !filterOff, "R11 idle flags after reset",
        {27'd0, reqReady, busy, done, fullErr, filterOff}, 32'h10);
    chk(extStartPtr == 0 && tableEndPtr == 0, "R11 pointers after reset",
        {16'(extStartPtr), 16'(tableEndPtr)}, 32'd0);
  endtask

  task automatic insertOp(input bit ext, input logic [2:0] ctrl, input logic [28:0] id, input string extTag);
    bit expFull, sawDone, sawErr;
    int guard;
    logic [15:0] s16;
    logic [31:0] e32;
    s16 = {ctrl, 2'b00, id[10:0]};
    e32 = {ctrl, id};
    expFull = ((sCnt + 1) / 2 + eCnt) >= DEPTH;
    chk(reqReady == 1'b1, "R10 ready when idle", {31'd0, reqReady}, 32'd1);
    reqValid = 1; reqExt = ext; reqCtrl = ctrl; reqId = id;
    @(negedge clk);
    sawDone = done; sawErr = fullErr;
    chk(busy && !reqReady, "R10 busy and not ready after accept", {30'd0, busy, reqReady}, 32'd2);
    // hold-off probe: junk request while busy must be ignored
    reqExt = ~ext; reqCtrl = ~ctrl; reqId = ~id;
    guard = 0;
    while (!(sawDone || sawErr) && guard < 4000) begin
      @(negedge clk);
      reqValid = 0;
      sawDone = done; sawErr = fullErr;
      guard++;
    end
    reqValid = 0;
    if (expFull) begin
      chk(sawErr && !sawDone, "R8 refusal pulse", {30'd0, sawErr, sawDone}, 32'd2);
    end else begin
      chk(sawDone && !sawErr, "R10 done pulse", {30'd0, sawDone, sawErr}, 32'd2);
      chk(filterOff == 1'b0, "R9 filter on in done cycle", {31'd0, filterOff}, 32'd0);
      modelAdd(ext, s16, e32);
    end
    @(negedge clk);
    chk(!done && !fullErr && reqReady, "R10 single-cycle pulse then ready",
        {29'd0, done, fullErr, reqReady}, 32'd1);
    checkTable(extTag);
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    int refused;
    int unsigned r;
    doReset();

    // R1: single standard entry into an empty table
    insertOp(0, 3'd5, 29'h123, "R6 ext word");
    chk(mem[0] == {3'd5, 2'b00, 11'h123, 16'hFFFF}, "R1 std encoding", mem[0], {3'd5, 2'b00, 11'h123, 16'hFFFF});
    // R2: extended entry lands right after the std word
    insertOp(1, 3'd6, 29'h1ABCDEF, "R6 ext word");
    chk(mem[1] == {3'd6, 29'h1ABCDEF}, "R2 ext encoding", mem[1], {3'd6, 29'h1ABCDEF});
    insertOp(1, 3'd1, 29'h0000042, "R6 ext insert at front");
    insertOp(0, 3'd0, 29'h7FF, "R6 ext word");
    // R5: std count even with ext present: ext section moves up
    insertOp(0, 3'd0, 29'h001, "R5 ext moved up");
    insertOp(0, 3'd5, 29'h123, "R5 ext moved up");
    insertOp(1, 3'd7, 29'h1FFFFFFF, "R6 ext max value");

    // near-exhaustive mixed sweep until the table refuses twice
    refused = 0;
    for (int n = 0; n < 120 && refused < 2; n++) begin
      r = rnd();
      if (((sCnt + 1) / 2 + eCnt) >= DEPTH) refused++;
      if (r[0]) insertOp(1, 3'(r[3:2]), (r[4] ? 29'(r[7:5]) : 29'(r[28:5])), "R5/R6 ext word sweep");
      else      insertOp(0, 3'(r[3:2]), 29'(r[7:4]), "R5/R6 ext word sweep");
    end
    chk(refused == 2, "R8 sweep reached full", 32'(refused), 32'd2);

    // standard-only, descending identifiers: every insert lands at the front
    doReset();
    for (int i = 20; i > 0; i--) insertOp(0, 3'd2, 29'(i * 37), "R6 ext word");
    // duplicates go after equal entries
    insertOp(0, 3'd2, 29'(37 * 5), "R6 ext word");

    // extended first in descending order, then standard entries forcing moves
    doReset();
    for (int i = 6; i > 0; i--) insertOp(1, 3'(i % 4), 29'(i * 1000), "R6 ext descending");
    for (int i = 0; i < 6; i++) insertOp(0, 3'(i % 2), 29'(100 - i * 7), "R5 ext moved by std insert");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule